// File: doc/BRIEF.md
# Two-channel biphase-mark line encoder

This block merges two timing-and-control channels into one self-clocking serial line for a central broadcast transmitter. The first channel carries one trigger-accept bit per bunch crossing. The second channel carries framed broadcast commands. In every crossing period the block sends one bit-cell for each channel and biphase-mark codes them. The line clock runs at four times the crossing rate, so each bit-cell takes two line-clock cycles (two half-cells).

All logic runs on the line clock. The crossing clock comes in as a level that is synchronous to the line clock. Its sampled rising edge marks phase 0 of the crossing and realigns the internal phase counter. The trigger strobe is sampled in that phase-0 cycle.

Command frames enter through a valid/ready handshake. A transfer happens in a cycle where `frame_valid_i` and `frame_ready_o` are both high. `frame_ready_o` is high only in the phase-0 cycle of a crossing, and only while no frame is being shifted out. While ready is low, the sender must hold valid, the format bit and the data steady. While the command channel has no frame, it sends logic 1.

Top module: `abx_line_encoder`

## Requirements
- R1: While reset is asserted, `line_o` is low. The first crossing after reset carries trigger bit 0 and command bit 1 (idle).
- R2: The line level changes at the start of every bit-cell, that is, twice per crossing period.
- R3: The line level also changes in the middle of a bit-cell exactly when that cell's bit is 1.
- R4: Each crossing period has two bit-cells. The first carries the trigger bit and the second carries the command bit. The trigger bit is the value of `l1a_i` sampled in the cycle where the rising edge of the crossing clock is seen. That cycle is phase 0 of the crossing.
- R5: With no frame in progress and no frame accepted, the command cell carries 1.
- R6: A short frame (`frame_long_i`=0) is sent as the command bits of consecutive crossings in this order: start bit 0, format bit 0, 8 payload bits taken from `frame_data_i[7:0]` MSB first, then stop bit 1.
- R7: A long frame (`frame_long_i`=1) is sent as start bit 0, format bit 1, 32 payload bits taken from `frame_data_i[31:0]` MSB first, then stop bit 1.
- R8: `frame_ready_o` is high only in a phase-0 cycle when no frame is in progress. A frame is accepted only when valid and ready are both high. Its start bit goes out in the command cell of that same crossing. Frame inputs offered while ready is low have no effect on the line.
- R9: A request that is already waiting is accepted in the crossing right after the stop bit, so frames can follow each other with no idle cell between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_line_i | input | 1 | Line clock, four cycles per crossing |
| rst_i | input | 1 | Synchronous reset, active high |
| bx_clk_i | input | 1 | Crossing clock level, synchronous to the line clock |
| l1a_i | input | 1 | Trigger-accept strobe, sampled at phase 0 |
| frame_valid_i | input | 1 | A command frame is offered |
| frame_ready_o | output | 1 | A frame can be accepted in this cycle |
| frame_long_i | input | 1 | Frame format: 1 long, 0 short |
| frame_data_i | input | 32 | Frame payload; a short frame uses bits [7:0] |
| line_o | output | 1 | Biphase-mark coded serial line |

## Verification
A trigger bit and the start bit of a command frame can land in the same crossing period. Likewise, a frame's stop bit and the acceptance of the next waiting request can meet at the same crossing boundary. The bench raises the trigger strobe in the crossing where a frame is accepted and throughout the frames. It also keeps a second request pending while the first frame is still busy. A bench-side decoder recovers both channels from the line's transitions. Each crossing's recovered bits are compared with the strobe pattern and with the frame bit order the requirements give, and the ready line is checked in every crossing.

// File: rtl/abx_pkg.sv
package abx_pkg;
  localparam int PHASE_W = 2;
  typedef logic [PHASE_W-1:0] phase_t;
  // order of half-cells inside one crossing period
  localparam phase_t PH_A_EDGE = 2'd0;
  localparam phase_t PH_A_MID  = 2'd1;
  localparam phase_t PH_B_EDGE = 2'd2;
  localparam phase_t PH_B_MID  = 2'd3;
endpackage

// File: rtl/abx_phase_gen.sv
module abx_phase_gen
  import abx_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   bx_clk_i,
  output phase_t phase_o,
  output logic   xing_start_o
);
  logic   bx_q;
  logic   bx_rise;
  phase_t ph_q;

  assign bx_rise      = bx_clk_i & ~bx_q;
  assign phase_o      = bx_rise ? PH_A_EDGE : ph_q;
  assign xing_start_o = (phase_o == PH_A_EDGE);

  always_ff @(posedge clk) begin
    if (rst) begin
      bx_q <= 1'b0;
      ph_q <= PH_A_EDGE;
    end else begin
      bx_q <= bx_clk_i;
      ph_q <= phase_o + phase_t'(1);
    end
  end

  // R4: a seen crossing edge is always followed by the A mid half-cell
  p_rise_then_amid_r4: assert property (@(posedge clk) disable iff (rst)
    bx_rise |=> (phase_o == PH_A_MID) || bx_rise);
endmodule

// File: rtl/abx_bchan_framer.sv
module abx_bchan_framer #(
  parameter int SHORT_W = 8,
  parameter int LONG_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xing_start_i,
  input  logic              valid_i,
  input  logic              long_i,
  input  logic [LONG_W-1:0] data_i,
  output logic              ready_o,
  output logic              bbit_o
);
  localparam int SRW   = LONG_W + 2;
  localparam int PAD   = LONG_W - SHORT_W;
  localparam int CNT_W = $clog2(SRW + 1);

  logic [SRW-1:0]   sr_q;
  logic [CNT_W-1:0] left_q;
  logic             busy_q;
  logic             take;

  assign ready_o = xing_start_i & ~busy_q;
  assign take    = valid_i & ready_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
      bbit_o <= 1'b1;
    end else if (xing_start_i) begin
      if (take) begin
        bbit_o <= 1'b0;
        busy_q <= 1'b1;
        if (long_i) begin
          sr_q   <= {1'b1, data_i, 1'b1};
          left_q <= CNT_W'(LONG_W + 2);
        end else begin
          sr_q   <= {1'b0, data_i[SHORT_W-1:0], 1'b1, {PAD{1'b1}}};
          left_q <= CNT_W'(SHORT_W + 2);
        end
      end else if (busy_q) begin
        bbit_o <= sr_q[SRW-1];
        sr_q   <= {sr_q[SRW-2:0], 1'b1};
        left_q <= left_q - CNT_W'(1);
        if (left_q == CNT_W'(1)) busy_q <= 1'b0;
      end else begin
        bbit_o <= 1'b1;
      end
    end
  end

  // R8: an accepted frame sends its start bit and holds off further requests
  p_start_bit_r8: assert property (@(posedge clk) disable iff (rst)
    take |=> !bbit_o && !ready_o);
  // R5: an idle crossing with nothing accepted sends 1
  p_idle_one_r5: assert property (@(posedge clk) disable iff (rst)
    xing_start_i && !busy_q && !valid_i |=> bbit_o);
  // R6: the command bit only moves at a crossing start
  p_bit_held_r6: assert property (@(posedge clk) disable iff (rst)
    !xing_start_i |=> $stable(bbit_o));
  // R9: the cell that ends a frame is its stop bit
  p_stop_one_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> bbit_o);
endmodule

// File: rtl/abx_bpm_encoder.sv
module abx_bpm_encoder
  import abx_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_t phase_i,
  input  logic   l1a_i,
  input  logic   bbit_i,
  output logic   line_o
);
  logic a_q;
  logic flip;

  always_comb begin
    unique case (phase_i)
      PH_A_EDGE: flip = 1'b1;
      PH_A_MID:  flip = a_q;
      PH_B_EDGE: flip = 1'b1;
      default:   flip = bbit_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= 1'b0;
      line_o <= 1'b0;
    end else begin
      if (phase_i == PH_A_EDGE) a_q <= l1a_i;
      line_o <= line_o ^ flip;
    end
  end

  // R2: a transition at the start of every bit-cell
  p_cell_edge_r2: assert property (@(posedge clk) disable iff (rst)
    (phase_i == PH_A_EDGE) || (phase_i == PH_B_EDGE) |=> line_o != $past(line_o));
  // R3: a zero trigger bit keeps the level through mid-cell
  p_mid_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (phase_i == PH_A_MID) && !a_q |=> $stable(line_o));
  // R3: a one command bit flips the level at mid-cell
  p_mid_one_r3: assert property (@(posedge clk) disable iff (rst)
    (phase_i == PH_B_MID) && bbit_i |=> line_o != $past(line_o));
endmodule

// File: rtl/abx_line_encoder.sv
module abx_line_encoder
  import abx_pkg::*;
#(
  parameter int SHORT_W = 8,
  parameter int LONG_W  = 32
) (
  input  logic              clk_line_i,
  input  logic              rst_i,
  input  logic              bx_clk_i,
  input  logic              l1a_i,
  input  logic              frame_valid_i,
  output logic              frame_ready_o,
  input  logic              frame_long_i,
  input  logic [LONG_W-1:0] frame_data_i,
  output logic              line_o
);
  phase_t phase;
  logic   xing_start;
  logic   bbit;

  abx_phase_gen u_phase (
    .clk          (clk_line_i),
    .rst          (rst_i),
    .bx_clk_i     (bx_clk_i),
    .phase_o      (phase),
    .xing_start_o (xing_start)
  );

  abx_bchan_framer #(.SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_framer (
    .clk          (clk_line_i),
    .rst          (rst_i),
    .xing_start_i (xing_start),
    .valid_i      (frame_valid_i),
    .long_i       (frame_long_i),
    .data_i       (frame_data_i),
    .ready_o      (frame_ready_o),
    .bbit_o       (bbit)
  );

  abx_bpm_encoder u_enc (
    .clk     (clk_line_i),
    .rst     (rst_i),
    .phase_i (phase),
    .l1a_i   (l1a_i),
    .bbit_i  (bbit),
    .line_o  (line_o)
  );

  // R8: ready is offered only at a crossing start
  p_ready_at_start_r8: assert property (@(posedge clk_line_i) disable iff (rst_i)
    frame_ready_o |-> xing_start);
endmodule

// File: tb/abx_line_encoder_tb_top.sv
`timescale 1ns/1ps
module abx_line_encoder_tb_top;
  localparam int SW = 8;
  localparam int LW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bx = 1'b0;
  logic l1a = 1'b0;
  logic fvalid = 1'b0;
  logic flong = 1'b0;
  logic [LW-1:0] fdata = '0;
  logic fready;
  logic line;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  abx_line_encoder #(.SHORT_W(SW), .LONG_W(LW)) dut_i (
    .clk_line_i    (clk),
    .rst_i         (rst),
    .bx_clk_i      (bx),
    .l1a_i         (l1a),
    .frame_valid_i (fvalid),
    .frame_ready_o (fready),
    .frame_long_i  (flong),
    .frame_data_i  (fdata),
    .line_o        (line)
  );

  always #10 clk = ~clk;

  // crossing clock and line decoder, both on the falling edge
  logic [1:0] c = 2'd0;
  logic h0a, h1a, h0b, h1b, prev_h1 = 1'b0;
  logic dec_a, dec_b, dec_edges;
  event xb_ev;

  always @(negedge clk) begin
    case (c)
      2'd2: h0a = line;
      2'd3: h1a = line;
      2'd0: h0b = line;
      default: begin
        h1b = line;
        dec_a = h0a ^ h1a;
        dec_b = h0b ^ h1b;
        dec_edges = (h0a != prev_h1) && (h0b != h1a);
        prev_h1 = h1b;
      end
    endcase
    c = c + 2'd1;
    bx = c[1];
    if (c == 2'd2) -> xb_ev;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one crossing: drive inputs, sample ready, collect decoded cells
  task automatic xing(input logic a, input logic v, output logic rdy,
                      output logic ra, output logic rb);
    l1a = a;
    fvalid = v;
    #2 rdy = fready;
    @(xb_ev);
    ra = dec_a;
    rb = dec_b;
    chk(dec_edges, "R2 cell-boundary transitions", dec_edges, 1);
  endtask

  function automatic logic exp_bit(input logic lng, input logic [LW-1:0] d, input int i);
    int w = lng ? LW : SW;
    if (i == 0) return 1'b0;
    if (i == 1) return lng;
    if (i <= w + 1) return d[w-1-(i-2)];
    return 1'b1;
  endfunction

  task automatic t_reset();
    logic r, a, b;
    repeat (3) @(negedge clk);
    chk(line == 1'b0, "R1 line low in reset", line, 0);
    @(negedge clk);
    chk(line == 1'b0, "R1 line low in reset", line, 0);
    @(xb_ev);
    rst = 1'b0;
    @(xb_ev);
    @(xb_ev);
    l1a = 1'b0;
    fvalid = 1'b0;
    @(xb_ev);
    chk(dec_a == 1'b0, "R1 first trigger bit", dec_a, 0);
    chk(dec_b == 1'b1, "R1 first command bit idle", dec_b, 1);
    xing(1'b0, 1'b0, r, a, b);
    chk(r == 1'b1, "R8 ready when idle", r, 1);
  endtask

  task automatic t_trigger_pattern();
    logic [9:0] pat = 10'b1011001110;
    logic r, a, b;
    for (int i = 0; i < 10; i++) begin
      xing(pat[i], 1'b0, r, a, b);
      chk(a == pat[i], "R4 trigger bit in first cell", a, pat[i]);
      chk(b == 1'b1, "R5 idle command cell", b, 1);
    end
    // R3: a one bit gives a mid-cell transition, a zero none
    chk(dec_a == pat[9], "R3 mid-cell coding", dec_a, pat[9]);
  endtask

  task automatic t_ignored_inputs();
    logic r, a, b;
    flong = 1'b1;
    fdata = 32'h0000_0000;
    for (int i = 0; i < 4; i++) begin
      fdata = fdata ^ 32'hFFFF_0F0F;
      xing(1'b0, 1'b0, r, a, b);
      chk(b == 1'b1, "R5 data without valid has no effect", b, 1);
    end
  endtask

  task automatic t_frame(input logic lng, input logic [LW-1:0] d, input logic [63:0] apat);
    int n = (lng ? LW : SW) + 3;
    logic r, a, b;
    flong = lng;
    fdata = d;
    for (int i = 0; i <= n; i++) begin
      xing(apat[i % 64], (i == 0), r, a, b);
      if (i == 0) fdata = ~d;
      chk(r == ((i == 0) || (i == n)), "R8 ready only when not busy", r, (i == 0) || (i == n));
      chk(a == apat[i % 64], "R4 trigger bit beside frame", a, apat[i % 64]);
      chk(b == exp_bit(lng, d, i), lng ? "R7 long frame bit" : "R6 short frame bit",
          b, exp_bit(lng, d, i));
    end
  endtask

  task automatic t_back_to_back();
    logic r, a, b;
    logic [LW-1:0] d1 = 32'h0000_003C;
    logic [LW-1:0] d2 = 32'h8000_0001;
    flong = 1'b0;
    fdata = d1;
    xing(1'b1, 1'b1, r, a, b);
    chk(r == 1'b1 && b == 1'b0, "R8 first frame accepted", b, 0);
    flong = 1'b1;
    fdata = d2;
    for (int i = 1; i <= SW + 2; i++) begin
      xing(1'b0, 1'b1, r, a, b);
      chk(r == 1'b0, "R8 held off while busy", r, 0);
      chk(b == exp_bit(1'b0, d1, i), "R8 pending request leaves frame intact", b, exp_bit(1'b0, d1, i));
    end
    xing(1'b1, 1'b1, r, a, b);
    chk(r == 1'b1, "R9 ready right after stop", r, 1);
    chk(b == 1'b0, "R9 back-to-back start bit", b, 0);
    chk(a == 1'b1, "R4 trigger with frame start", a, 1);
    for (int i = 1; i <= LW + 3; i++) begin
      xing(1'b0, 1'b0, r, a, b);
      chk(b == exp_bit(1'b1, d2, i), "R7 second frame bit", b, exp_bit(1'b1, d2, i));
    end
  endtask

  initial begin
    t_reset();
    t_trigger_pattern();
    t_ignored_inputs();
    t_frame(1'b0, 32'h0000_00A5, 64'h0000_0000_0000_0F5B);
    t_frame(1'b1, 32'hDEAD_BEEF, 64'h0000_0005_A3C1_7E91);
    t_frame(1'b0, 32'h0000_0080, 64'hFFFF_FFFF_FFFF_FFFF);
    t_back_to_back();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule